// File: doc/BRIEF.md
# Debug Transport Request Responder

This block terminates the debug transport link on the target side. A scan-style transport hands it one 41-bit request word per scan. The word carries an operation code, a 7-bit register address and 32 bits of data. Reads and writes go out over a simple request/acknowledge register-bus port toward the debug registers. A NOP starts no access.

The block does not answer a request in the same scan. The response word it presents during a scan describes the request that came before it, so a host collects the data of a read with a following NOP. If a read or write arrives while the bus access before it is still outstanding, the block drops the new request and latches a busy condition. Busy stays latched until a clear pulse. Until then every request is dropped and every response reports busy.

Top module: `dmi_responder`

## Requirements
- R1: After reset the response word is all zeros and no bus access is requested.
- R2: Request word layout: op in bits 1:0 (0 = NOP, 1 = read, 2 = write, 3 = reserved), data in bits 33:2, address in bits 40:34. A read or write drives that address on the bus, with write enable set only for a write and the write data taken from bits 33:2.
- R3: The response word uses the same layout, with a status in bits 1:0 (0 = success, 2 = failed, 3 = busy). After a successful write, the next scan returns the written address and data with status 0.
- R4: After a read completes, the next scan returns the read address, the data the bus returned and status 0.
- R5: A NOP issued with nothing outstanding and no busy latched makes the next scan return address 0, data 0 and status 0.
- R6: Bus request, address, write data and write enable stay stable from request until acknowledge. The request drops in the cycle after acknowledge, and at most one access is outstanding.
- R7: A read or write that arrives while an access is outstanding is not issued, and it latches busy.
- R8: While busy is latched, every request is ignored: it starts no bus access and changes no reported address or data, and the response status is 3.
- R9: A pulse on the clear input removes latched busy, and later requests are handled normally.
- R10: An access that ends with the bus error flag reports status 2 on the next scan, with its address.
- R11: A reserved op (3) starts no bus access. The next scan returns its address with data 0 and status 2.
- R12: Status 3 is reported whenever an access is outstanding. A NOP or reserved op during that time is ignored and does not latch busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_valid_i | input | 1 | One-cycle strobe marking a completed scan |
| scan_word_i | input | 41 | Request word of the scan |
| busy_clr_i | input | 1 | Pulse that clears latched busy |
| resp_word_o | output | 41 | Response word captured by the transport at each scan |
| bus_req_o | output | 1 | Register-bus access request |
| bus_we_o | output | 1 | Register-bus write enable |
| bus_addr_o | output | 7 | Register-bus address |
| bus_wdata_o | output | 32 | Register-bus write data |
| bus_ack_i | input | 1 | Register-bus acknowledge, one cycle |
| bus_rdata_i | input | 32 | Register-bus read data, valid with acknowledge |
| bus_err_i | input | 1 | Register-bus error, valid with acknowledge |

## Verification
On every cycle the assertions check the bus handshake: the access fields hold until acknowledge, the request ends right after acknowledge, and an outstanding access always shows as busy. They also check that a read or write colliding with an outstanding access leaves busy reported, and that no new access starts while busy is latched. How the one-scan response lag works end to end can only be shown by the bench's scenarios. These cover the echoed address and data of writes and reads, the zero response after a NOP, the error and reserved-op statuses, and recovery through the clear pulse. In them a behavioural model is compared with the response word and the bus port on every clock, and the scenarios check explicit values.

// File: rtl/dmi_resp_pkg.sv
package dmi_resp_pkg;
  localparam int unsigned OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    REQ_NOP  = 2'd0,
    REQ_RD   = 2'd1,
    REQ_WR   = 2'd2,
    REQ_RSVD = 2'd3
  } req_op_e;

  typedef enum logic [OP_W-1:0] {
    ST_OK   = 2'd0,
    ST_RSV  = 2'd1,
    ST_FAIL = 2'd2,
    ST_BUSY = 2'd3
  } resp_st_e;
endpackage

// File: rtl/dmi_field_codec.sv
module dmi_field_codec #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned OP_W   = dmi_resp_pkg::OP_W,
  localparam int unsigned WORD_W = ADDR_W + DATA_W + OP_W
) (
  input  logic [WORD_W-1:0]   req_word_i,
  output dmi_resp_pkg::req_op_e req_op_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [DATA_W-1:0]   req_data_o,
  input  logic [ADDR_W-1:0]   rsp_addr_i,
  input  logic [DATA_W-1:0]   rsp_data_i,
  input  dmi_resp_pkg::resp_st_e rsp_st_i,
  output logic [WORD_W-1:0]   rsp_word_o
);
  localparam int unsigned DATA_LSB = OP_W;
  localparam int unsigned ADDR_LSB = OP_W + DATA_W;

  assign req_op_o   = dmi_resp_pkg::req_op_e'(req_word_i[OP_W-1:0]);
  assign req_data_o = req_word_i[ADDR_LSB-1:DATA_LSB];
  assign req_addr_o = req_word_i[WORD_W-1:ADDR_LSB];
  assign rsp_word_o = {rsp_addr_i, rsp_data_i, rsp_st_i};
endmodule

// File: rtl/dmi_bus_port.sv
module dmi_bus_port #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              issue_we_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic [DATA_W-1:0] issue_data_i,
  input  logic              ack_i,
  output logic              pending_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue_i && !req_q) begin
      req_q   <= 1'b1;
      we_q    <= issue_we_i;
      addr_q  <= issue_addr_i;
      wdata_q <= issue_we_i ? issue_data_i : '0;
    end else if (req_q && ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign pending_o = req_q;
  assign req_o     = req_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
endmodule

// File: rtl/dmi_resp_track.sv
module dmi_resp_track #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scan_valid_i,
  input  dmi_resp_pkg::req_op_e   op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    busy_clr_i,
  input  logic                    pending_i,
  input  logic                    pend_we_i,
  input  logic                    ack_i,
  input  logic [DATA_W-1:0]       rdata_i,
  input  logic                    err_i,
  output logic                    issue_o,
  output logic                    issue_we_o,
  output logic [ADDR_W-1:0]       rec_addr_o,
  output logic [DATA_W-1:0]       rec_data_o,
  output dmi_resp_pkg::resp_st_e  rec_st_o
);
  import dmi_resp_pkg::*;

  logic              sticky_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  resp_st_e          st_q;
  logic              is_acc, accept, set_busy;

  always_comb begin
    is_acc   = (op_i == REQ_RD) || (op_i == REQ_WR);
    accept   = scan_valid_i && !sticky_q && !pending_i;
    set_busy = scan_valid_i && !sticky_q && pending_i && is_acc;
  end

  assign issue_o    = accept && is_acc;
  assign issue_we_o = (op_i == REQ_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      st_q   <= ST_OK;
    end else begin
      if (accept) begin
        unique case (op_i)
          REQ_NOP: begin
            addr_q <= '0;
            data_q <= '0;
            st_q   <= ST_OK;
          end
          REQ_RSVD: begin
            addr_q <= addr_i;
            data_q <= '0;
            st_q   <= ST_FAIL;
          end
          REQ_RD: begin
            addr_q <= addr_i;
            data_q <= '0;
            st_q   <= ST_OK;
          end
          default: begin
            addr_q <= addr_i;
            data_q <= data_i;
            st_q   <= ST_OK;
          end
        endcase
      end
      if (pending_i && ack_i) begin
        if (!pend_we_i) data_q <= err_i ? '0 : rdata_i;
        st_q <= err_i ? ST_FAIL : ST_OK;
      end
    end
  end

  // clear takes priority over a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sticky_q <= 1'b0;
    else if (busy_clr_i) sticky_q <= 1'b0;
    else if (set_busy)   sticky_q <= 1'b1;
  end

  assign rec_addr_o = addr_q;
  assign rec_data_o = data_q;
  assign rec_st_o   = (sticky_q || pending_i) ? ST_BUSY : st_q;
endmodule

// File: rtl/dmi_responder.sv
module dmi_responder #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORD_W = ADDR_W + DATA_W + dmi_resp_pkg::OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_valid_i,
  input  logic [WORD_W-1:0] scan_word_i,
  input  logic              busy_clr_i,
  output logic [WORD_W-1:0] resp_word_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_err_i
);
  import dmi_resp_pkg::*;

  req_op_e           req_op;
  logic [ADDR_W-1:0] req_addr, rec_addr;
  logic [DATA_W-1:0] req_data, rec_data;
  resp_st_e          rec_st;
  logic              issue, issue_we, pending;

  dmi_field_codec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_codec (
    .req_word_i (scan_word_i),
    .req_op_o   (req_op),
    .req_addr_o (req_addr),
    .req_data_o (req_data),
    .rsp_addr_i (rec_addr),
    .rsp_data_i (rec_data),
    .rsp_st_i   (rec_st),
    .rsp_word_o (resp_word_o)
  );

  dmi_resp_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scan_valid_i (scan_valid_i),
    .op_i         (req_op),
    .addr_i       (req_addr),
    .data_i       (req_data),
    .busy_clr_i   (busy_clr_i),
    .pending_i    (pending),
    .pend_we_i    (bus_we_o),
    .ack_i        (bus_ack_i),
    .rdata_i      (bus_rdata_i),
    .err_i        (bus_err_i),
    .issue_o      (issue),
    .issue_we_o   (issue_we),
    .rec_addr_o   (rec_addr),
    .rec_data_o   (rec_data),
    .rec_st_o     (rec_st)
  );

  dmi_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .issue_we_i   (issue_we),
    .issue_addr_i (req_addr),
    .issue_data_i (req_data),
    .ack_i        (bus_ack_i),
    .pending_o    (pending),
    .req_o        (bus_req_o),
    .we_o         (bus_we_o),
    .addr_o       (bus_addr_o),
    .wdata_o      (bus_wdata_o)
  );
endmodule

// File: rtl/dmi_responder_chk.sv
module dmi_responder_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WORD_W = ADDR_W + DATA_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scan_valid_i,
  input logic [WORD_W-1:0] scan_word_i,
  input logic              busy_clr_i,
  input logic [WORD_W-1:0] resp_word_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  logic resp_busy, acc_op;
  assign resp_busy = (resp_word_o[1:0] == 2'd3);
  assign acc_op    = (scan_word_i[1:0] == 2'd1) || (scan_word_i[1:0] == 2'd2);

  a_r6_hold_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_we_o)));

  a_r6_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i) |=> !bus_req_o);

  a_r12_pending_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> resp_busy);

  a_r7_collision_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && scan_valid_i && acc_op && !busy_clr_i) |=> resp_busy);

  a_r8_no_issue_when_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && resp_busy && scan_valid_i && !busy_clr_i) |=> !bus_req_o);
endmodule

bind dmi_responder dmi_responder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scan_valid_i (scan_valid_i),
  .scan_word_i  (scan_word_i),
  .busy_clr_i   (busy_clr_i),
  .resp_word_o  (resp_word_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i)
);

// File: tb/dmi_responder_test.sv
`timescale 1ns/1ps
module dmi_responder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scan_valid_i = 1'b0;
  logic [40:0] scan_word_i = '0;
  logic        busy_clr_i = 1'b0;
  logic [40:0] resp_word_o;
  logic        bus_req_o, bus_we_o;
  logic [6:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_err_i = 1'b0;

  int checks = 0, fails = 0;
  int lat = 0, wait_cnt = 0;
  logic [31:0] mem [128];
  logic [6:0]  seen_addr;
  logic        seen_we;
  logic [31:0] seen_wdata;

  always #4 clk_i = ~clk_i;

  dmi_responder uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // bench register slave
  always @(negedge clk_i) begin
    if (bus_ack_i) begin
      bus_ack_i = 1'b0; bus_err_i = 1'b0; wait_cnt = 0;
    end else if (bus_req_o && rst_ni) begin
      if (wait_cnt >= lat) begin
        bus_ack_i   = 1'b1;
        bus_err_i   = (bus_addr_o == 7'h7f);
        bus_rdata_i = bus_err_i ? 32'h0 : mem[bus_addr_o];
        seen_addr = bus_addr_o; seen_we = bus_we_o; seen_wdata = bus_wdata_o;
        if (bus_we_o && !bus_err_i) mem[bus_addr_o] = bus_wdata_o;
      end else wait_cnt++;
    end
  end

  // behavioural reference model
  bit          pend_m, pend_we_m, sticky_m;
  logic [6:0]  m_addr, b_addr;
  logic [31:0] m_data, b_wd;
  logic [1:0]  m_st;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_m = 0; pend_we_m = 0; sticky_m = 0;
      m_addr = 0; m_data = 0; m_st = 0; b_addr = 0; b_wd = 0;
    end else begin
      bit old_pend;
      old_pend = pend_m;
      if (scan_valid_i) begin
        logic [1:0] op;
        op = scan_word_i[1:0];
        if (sticky_m) ;
        else if (old_pend) begin
          if (op == 2'd1 || op == 2'd2) sticky_m = 1;
        end else if (op == 2'd0) begin
          m_addr = 0; m_data = 0; m_st = 0;
        end else if (op == 2'd3) begin
          m_addr = scan_word_i[40:34]; m_data = 0; m_st = 2;
        end else begin
          pend_m = 1; pend_we_m = (op == 2'd2);
          m_addr = scan_word_i[40:34]; b_addr = m_addr;
          m_data = pend_we_m ? scan_word_i[33:2] : 32'h0; b_wd = m_data; m_st = 0;
        end
      end
      if (old_pend && bus_ack_i) begin
        pend_m = 0;
        if (!pend_we_m) m_data = bus_err_i ? 32'h0 : bus_rdata_i;
        m_st = bus_err_i ? 2'd2 : 2'd0;
      end
      if (busy_clr_i) sticky_m = 0;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    check("R3/R12 model response", {23'h0, resp_word_o},
          {23'h0, m_addr, m_data, (sticky_m || pend_m) ? 2'd3 : m_st});
    check("R6 model bus request", {63'h0, bus_req_o}, {63'h0, pend_m});
    if (pend_m) check("R2 model bus fields", {23'h0, bus_we_o, bus_addr_o, bus_wdata_o},
                      {23'h0, pend_we_m, b_addr, b_wd});
  end

  task automatic scan(input logic [1:0] op, input logic [6:0] a, input logic [31:0] d,
                      output logic [40:0] got);
    @(negedge clk_i);
    got = resp_word_o;
    scan_word_i = {a, d, op};
    scan_valid_i = 1'b1;
    @(negedge clk_i);
    scan_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (bus_req_o) @(negedge clk_i);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [40:0] got;
    for (int i = 0; i < 128; i++) mem[i] = 32'hC0DE0000 + i;
    mem[7'h11] = 32'h00030c82;
    repeat (3) @(negedge clk_i);
    check("R1 reset response", {23'h0, resp_word_o}, 64'h0);
    check("R1 reset bus_req", {63'h0, bus_req_o}, 64'h0);
    rst_ni = 1'b1;

    // write then NOP
    lat = 0;
    scan(2'd2, 7'h10, 32'h80000001, got);
    check("R5 idle before first scan", {23'h0, got}, 64'h0);
    wait_idle();
    check("R2 write fields", {23'h0, seen_we, seen_addr, seen_wdata}, {23'h0, 1'b1, 7'h10, 32'h80000001});
    scan(2'd0, 7'h00, 32'h0, got);
    check("R3 write echo", {23'h0, got}, {23'h0, 7'h10, 32'h80000001, 2'd0});

    // read collected by NOP
    scan(2'd1, 7'h11, 32'hFFFFFFFF, got);
    check("R5 NOP response", {23'h0, got}, 64'h0);
    wait_idle();
    check("R2 read fields", {23'h0, seen_we, seen_addr}, {23'h0, 1'b0, 7'h11});
    scan(2'd0, 7'h00, 32'h0, got);
    check("R4 read data", {23'h0, got}, {23'h0, 7'h11, 32'h00030c82, 2'd0});
    scan(2'd0, 7'h00, 32'h0, got);
    check("R5 NOP after NOP", {23'h0, got}, 64'h0);

    // collision latches busy
    lat = 6;
    scan(2'd2, 7'h20, 32'h00001234, got);
    scan(2'd1, 7'h21, 32'h0, got);
    check("R12 busy while outstanding", {23'h0, got}, {23'h0, 7'h20, 32'h00001234, 2'd3});
    wait_idle();
    scan(2'd2, 7'h30, 32'hDEADBEEF, got);
    check("R7 busy latched", {62'h0, got[1:0]}, 64'd3);
    @(negedge clk_i);
    check("R8 no access while latched", {63'h0, bus_req_o}, 64'h0);
    scan(2'd0, 7'h00, 32'h0, got);
    check("R8 ignored request", {23'h0, got}, {23'h0, 7'h20, 32'h00001234, 2'd3});
    check("R8 memory untouched", {32'h0, mem[7'h30]}, {32'h0, 32'hC0DE0030});
    @(negedge clk_i); busy_clr_i = 1'b1;
    @(negedge clk_i); busy_clr_i = 1'b0;
    scan(2'd0, 7'h00, 32'h0, got);
    check("R9 cleared", {23'h0, got}, {23'h0, 7'h20, 32'h00001234, 2'd0});

    // NOP during outstanding read
    lat = 4;
    scan(2'd1, 7'h11, 32'h0, got);
    scan(2'd0, 7'h00, 32'h0, got);
    check("R12 NOP sees busy", {23'h0, got}, {23'h0, 7'h11, 32'h0, 2'd3});
    wait_idle();
    scan(2'd0, 7'h00, 32'h0, got);
    check("R12 NOP ignored, no latch", {23'h0, got}, {23'h0, 7'h11, 32'h00030c82, 2'd0});

    // bus error
    lat = 1;
    scan(2'd1, 7'h7f, 32'h0, got);
    wait_idle();
    scan(2'd0, 7'h00, 32'h0, got);
    check("R10 error status", {23'h0, got}, {23'h0, 7'h7f, 32'h0, 2'd2});

    // reserved op
    scan(2'd3, 7'h05, 32'h0000FFFF, got);
    check("R11 no access", {63'h0, bus_req_o}, 64'h0);
    scan(2'd0, 7'h00, 32'h0, got);
    check("R11 reserved status", {23'h0, got}, {23'h0, 7'h05, 32'h0, 2'd2});

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule